// File: doc/BRIEF.md
# Key-Protected GPIO Bank Controller

This block is a memory-mapped general-purpose I/O controller for 70 pads, grouped into three banks of at most 32 pins. A pad's behaviour comes from two mode bits and one output data bit. With these, a pad can act as an input, a push-pull output, an open-drain output that pulls low, or an open-drain output that pulls high. Software sets output data through a plain register or through write-one-to-set and write-one-to-clear aliases, so it never needs a read-modify-write. It reads pad levels through a two-flop synchronizer.

The mode registers are guarded. They accept writes only after software writes a 16-bit key to a separate lock register. Software writes zero to the lock register to protect the modes again. The bus is a single-cycle 32-bit write/read port, and read data is registered.

Top module: `keyed_gpio_ctrl`

## Requirements
- R1: After reset every pad output-enable and output value is 0, all mode and data registers read 0, and the lock register reads 0.
- R2: A write to the lock register (address 0x300) with bits [15:0] = 0xD42F makes bit 31 read 1. A write with key 0x0000 makes it read 0. Any other key leaves bit 31 unchanged. All other lock bits read 0.
- R3: While bit 31 of the lock reads 0, writes to mode1 (0x08), mode0 (0x0C), mode1-clear (0x50), mode0-set (0x54) and mode0-clear (0x58) have no effect.
- R4: A pin with {mode1,mode0} = 00 never drives its pad (output-enable 0) for either data value.
- R5: With {mode1,mode0} = 01 the pad is always enabled, and the pad value equals the data bit.
- R6: With {mode1,mode0} = 10 the pad is enabled only while the data bit is 0. The pad value equals the data bit.
- R7: With {mode1,mode0} = 11 the pad is enabled only while the data bit is 1. The pad value equals the data bit.
- R8: Register layout and data writes:
  - Writing data-out (0x00) replaces the data bits.
  - Data-set (0x14) sets the bits written as 1.
  - Data-clear (0x18) clears the bits written as 1.
  - Zero bits of data-set and data-clear leave data unchanged.
  - Mode0-set and mode0-clear act in the same way on mode0.
  - Mode1-clear clears mode1 bits.
- R9: Data-in (0x04) returns pad levels through two flops. A read whose data is captured on the first or second rising edge after a pad change returns the old level. A read captured on the third edge returns the new level, in every mode.
- R10: Bank n lies at byte address n*0x100. Pad p maps to bank p/32, bit p%32.
- R11: These all read as zero, and writes to them have no effect:
  - bits 6..31 of bank 2 registers;
  - offsets other than those in R8 and R9;
  - banks 3 and up apart from the lock address.
- R12: Read data appears on rd_data on the rising edge where rd_en is sampled high, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 12 | Byte address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| pad_in | input | 70 | Pad input levels |
| pad_out | output | 70 | Pad output values |
| pad_oe | output | 70 | Pad output enables |

## Verification
The assertions assume that wr_en and rd_en are never high in the same cycle. They also assume the address is stable while a strobe is high. The bench drives each access on its own cycle, changing inputs only on the falling edge. The assertions further assume pad_in changes only between clock edges. The bench updates pad_in on the falling edge together with its read strobe, so the synchronizer latency is counted in whole edges.

// File: rtl/keyed_gpio_pkg.sv
package keyed_gpio_pkg;
   localparam logic [7:0] OFS_DOUT  = 8'h00;
   localparam logic [7:0] OFS_DIN   = 8'h04;
   localparam logic [7:0] OFS_MODE1 = 8'h08;
   localparam logic [7:0] OFS_MODE0 = 8'h0C;
   localparam logic [7:0] OFS_DSET  = 8'h14;
   localparam logic [7:0] OFS_DCLR  = 8'h18;
   localparam logic [7:0] OFS_M1CLR = 8'h50;
   localparam logic [7:0] OFS_M0SET = 8'h54;
   localparam logic [7:0] OFS_M0CLR = 8'h58;

   typedef enum logic [1:0] {
      PM_INPUT  = 2'b00,
      PM_PUSH   = 2'b01,
      PM_OD_LOW = 2'b10,
      PM_OD_HI  = 2'b11
   } pin_mode_e;
endpackage

// File: rtl/gpio_key_lock.sv
module gpio_key_lock #(
   parameter int KEY_W = 16,
   parameter logic [KEY_W-1:0] ARM_KEY = 16'hD42F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [KEY_W-1:0] key,
   output logic             active
);
   logic active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active_q <= 1'b0;
      else if (wr) begin
         if (key == ARM_KEY) active_q <= 1'b1;
         else if (key == '0) active_q <= 1'b0;
      end
   end

   assign active = active_q;

   assert_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && key == ARM_KEY) |=> active);
   assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && key == '0) |=> !active);
   assert_badkey_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && key != ARM_KEY && key != '0) |=> (active == $past(active)));
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import keyed_gpio_pkg::*;
#(
   parameter int PINS   = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [7:0]        offset,
   input  logic [DATA_W-1:0] wdata,
   input  logic              lock_active,
   input  logic [PINS-1:0]   pad_in,
   output logic [DATA_W-1:0] rdata,
   output logic [PINS-1:0]   dout,
   output logic [PINS-1:0]   mode0,
   output logic [PINS-1:0]   mode1
);
   if (PINS < 1 || PINS > DATA_W) begin : g_bad_pins
      $error("gpio_bank_regs: PINS must be within 1..DATA_W");
   end

   logic [PINS-1:0] dout_q, mode0_q, mode1_q, sync1_q, din_q;
   logic [PINS-1:0] w;
   logic            mode_ok;

   assign w       = wdata[PINS-1:0];
   assign mode_ok = wr && lock_active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync1_q <= '0;
         din_q   <= '0;
      end else begin
         sync1_q <= pad_in;
         din_q   <= sync1_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= '0;
      end else if (wr) begin
         case (offset)
            OFS_DOUT: dout_q <= w;
            OFS_DSET: dout_q <= dout_q | w;
            OFS_DCLR: dout_q <= dout_q & ~w;
            default:  dout_q <= dout_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode0_q <= '0;
         mode1_q <= '0;
      end else if (mode_ok) begin
         case (offset)
            OFS_MODE1: mode1_q <= w;
            OFS_M1CLR: mode1_q <= mode1_q & ~w;
            OFS_MODE0: mode0_q <= w;
            OFS_M0SET: mode0_q <= mode0_q | w;
            OFS_M0CLR: mode0_q <= mode0_q & ~w;
            default: begin
               mode0_q <= mode0_q;
               mode1_q <= mode1_q;
            end
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      case (offset)
         OFS_DOUT:  rdata[PINS-1:0] = dout_q;
         OFS_DIN:   rdata[PINS-1:0] = din_q;
         OFS_MODE1: rdata[PINS-1:0] = mode1_q;
         OFS_MODE0: rdata[PINS-1:0] = mode0_q;
         default:   rdata = '0;
      endcase
   end

   assign dout  = dout_q;
   assign mode0 = mode0_q;
   assign mode1 = mode1_q;

   assert_mode_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_active |=> ($stable(mode0_q) && $stable(mode1_q)));
   assert_dset_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && offset == OFS_DSET) |=> ((dout_q & $past(w)) == $past(w)));
   assert_dclr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && offset == OFS_DCLR) |=> ((dout_q & $past(w)) == '0));
   assert_m0set_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && offset == OFS_M0SET) |=> ((mode0_q & ~$past(w)) == ($past(mode0_q) & ~$past(w))));
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
   import keyed_gpio_pkg::*;
#(
   parameter int PINS = 32
) (
   input  logic [PINS-1:0] dout,
   input  logic [PINS-1:0] mode0,
   input  logic [PINS-1:0] mode1,
   output logic [PINS-1:0] pad_out,
   output logic [PINS-1:0] pad_oe
);
   for (genvar i = 0; i < PINS; i++) begin : g_pin
      pin_mode_e m;
      assign m = pin_mode_e'({mode1[i], mode0[i]});
      always_comb begin
         case (m)
            PM_PUSH:   pad_oe[i] = 1'b1;
            PM_OD_LOW: pad_oe[i] = ~dout[i];
            PM_OD_HI:  pad_oe[i] = dout[i];
            default:   pad_oe[i] = 1'b0;
         endcase
      end
      assign pad_out[i] = dout[i];
   end
endmodule

// File: rtl/keyed_gpio_ctrl.sv
module keyed_gpio_ctrl #(
   parameter int NUM_PINS  = 70,
   parameter int BANK_PINS = 32,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 12,
   parameter int KEY_W     = 16,
   parameter logic [KEY_W-1:0]  ARM_KEY   = 16'hD42F,
   parameter logic [ADDR_W-1:0] LOCK_ADDR = 12'h300
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                rd_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wr_data,
   output logic [DATA_W-1:0]   rd_data,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe
);
   localparam int NUM_BANKS = (NUM_PINS + BANK_PINS - 1) / BANK_PINS;
   localparam int IDX_W     = ADDR_W - 8;

   if (KEY_W > DATA_W - 1) begin : g_bad_key
      $error("keyed_gpio_ctrl: key field overlaps status bit");
   end
   if (NUM_BANKS > (1 << IDX_W)) begin : g_bad_addr
      $error("keyed_gpio_ctrl: address too narrow for bank count");
   end
   if (int'(LOCK_ADDR[ADDR_W-1:8]) < NUM_BANKS) begin : g_bad_lock
      $error("keyed_gpio_ctrl: lock address collides with a bank");
   end

   logic [IDX_W-1:0]  bank_idx;
   logic [7:0]        offset;
   logic              lock_wr, lock_active;
   logic [DATA_W-1:0] bank_rdata [NUM_BANKS];
   logic [NUM_PINS-1:0] dout_all, mode0_all, mode1_all;
   logic [DATA_W-1:0] rd_next, rd_q;

   assign bank_idx = addr[ADDR_W-1:8];
   assign offset   = addr[7:0];
   assign lock_wr  = wr_en && (addr == LOCK_ADDR);

   gpio_key_lock #(.KEY_W(KEY_W), .ARM_KEY(ARM_KEY)) u_lock (
      .clk(clk), .rst_n(rst_n), .wr(lock_wr),
      .key(wr_data[KEY_W-1:0]), .active(lock_active));

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int LO   = b * BANK_PINS;
      localparam int PINS = ((NUM_PINS - LO) < BANK_PINS) ? (NUM_PINS - LO) : BANK_PINS;
      logic sel;
      assign sel = wr_en && (int'(bank_idx) == b);

      gpio_bank_regs #(.PINS(PINS), .DATA_W(DATA_W)) u_regs (
         .clk(clk), .rst_n(rst_n), .wr(sel), .offset(offset),
         .wdata(wr_data), .lock_active(lock_active),
         .pad_in(pad_in[LO +: PINS]), .rdata(bank_rdata[b]),
         .dout(dout_all[LO +: PINS]), .mode0(mode0_all[LO +: PINS]),
         .mode1(mode1_all[LO +: PINS]));

      gpio_pad_drive #(.PINS(PINS)) u_drive (
         .dout(dout_all[LO +: PINS]), .mode0(mode0_all[LO +: PINS]),
         .mode1(mode1_all[LO +: PINS]), .pad_out(pad_out[LO +: PINS]),
         .pad_oe(pad_oe[LO +: PINS]));
   end

   always_comb begin
      rd_next = '0;
      if (addr == LOCK_ADDR) begin
         rd_next[DATA_W-1] = lock_active;
      end else begin
         for (int b = 0; b < NUM_BANKS; b++) begin
            if (int'(bank_idx) == b) rd_next = bank_rdata[b];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_q <= '0;
      else if (rd_en) rd_q <= rd_next;
   end

   assign rd_data = rd_q;

   assert_input_hiz_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & ~(mode0_all | mode1_all)) == '0);
   assert_od_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & mode1_all & ~mode0_all & pad_out) == '0);
   assert_od_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & mode1_all & mode0_all & ~pad_out) == '0);
   assert_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode0_all & ~mode1_all) & ~pad_oe) == '0);
   assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));
endmodule

// File: tb/keyed_gpio_ctrl_test.sv
`timescale 1ns/1ps
module keyed_gpio_ctrl_test;
   localparam int NP = 70;
   logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wr_data = '0, rd_data;
   logic [NP-1:0] pad_in = '0, pad_out, pad_oe;
   int total = 0, bad = 0;
   bit done = 0;

   keyed_gpio_ctrl uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe));

   always #2.5 clk = ~clk;

   task automatic check(string tag, logic [NP-1:0] act, logic [NP-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_write(logic [11:0] a, logic [31:0] d);
      @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
      @(posedge clk); @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic bus_read(logic [11:0] a, output logic [31:0] d);
      @(negedge clk); addr = a; rd_en = 1'b1;
      @(posedge clk); @(negedge clk); rd_en = 1'b0; d = rd_data;
   endtask

   function automatic logic [NP-1:0] exp_oe(logic [NP-1:0] m1, logic [NP-1:0] m0, logic [NP-1:0] d);
      return (~m1 & m0) | (m1 & ~m0 & ~d) | (m1 & m0 & d);
   endfunction

   task automatic t_reset();
      logic [31:0] r;
      check("R1 oe", pad_oe, '0);
      check("R1 out", pad_out, '0);
      bus_read(12'h300, r); check("R1 lock", r, 0);
      bus_read(12'h00C, r); check("R1 mode0", r, 0);
      bus_read(12'h100, r); check("R1 dout", r, 0);
   endtask

   task automatic t_lock();
      logic [31:0] r;
      bus_write(12'h300, 32'h1234); bus_read(12'h300, r); check("R2 badkey idle", r, 0);
      bus_write(12'h300, 32'hD42F); bus_read(12'h300, r); check("R2 armed", r, 32'h8000_0000);
      bus_write(12'h300, 32'h5555); bus_read(12'h300, r); check("R2 badkey armed", r, 32'h8000_0000);
      bus_write(12'h300, 32'h0); bus_read(12'h300, r); check("R2 released", r, 0);
   endtask

   task automatic t_protect();
      logic [31:0] r;
      bus_write(12'h054, 32'hFFFF_FFFF);
      bus_write(12'h00C, 32'h0000_000F);
      bus_write(12'h008, 32'hFFFF_FFFF);
      bus_read(12'h00C, r); check("R3 mode0", r, 0);
      bus_read(12'h008, r); check("R3 mode1", r, 0);
      check("R3 oe", pad_oe, '0);
   endtask

   task automatic t_modes();
      logic [NP-1:0] m0 = '0, m1 = '0, d = '0;
      bus_write(12'h300, 32'hD42F);
      bus_write(12'h000, 32'h55); d[7:0] = 8'h55;
      bus_write(12'h054, 32'hCC); m0[7:0] = 8'hCC;
      bus_write(12'h008, 32'hF0); m1[7:0] = 8'hF0;
      check("R4 R5 R6 R7 oe", pad_oe, exp_oe(m1, m0, d));
      check("R5 out", pad_out, d);
      bus_write(12'h000, 32'hAA); d[7:0] = 8'hAA;
      check("R4 R6 R7 oe flip", pad_oe, exp_oe(m1, m0, d));
      bus_write(12'h050, 32'h30); m1[7:0] = 8'hC0;
      check("R8 m1clr oe", pad_oe, exp_oe(m1, m0, d));
      bus_write(12'h058, 32'h44); m0[7:0] = 8'h88;
      check("R8 m0clr oe", pad_oe, exp_oe(m1, m0, d));
      bus_write(12'h300, 32'h0);
      bus_write(12'h058, 32'hFF);
      check("R3 locked alias", pad_oe, exp_oe(m1, m0, d));
      bus_write(12'h300, 32'hD42F);
      bus_write(12'h00C, 32'h0); bus_write(12'h008, 32'h0);
      bus_write(12'h300, 32'h0);
      check("R4 all input", pad_oe, '0);
   endtask

   task automatic t_data();
      logic [31:0] r;
      bus_write(12'h000, 32'h0);
      bus_write(12'h100, 32'h0000_FFFF);
      bus_write(12'h114, 32'hFF00_0000);
      bus_write(12'h118, 32'h0000_00F0);
      bus_read(12'h100, r); check("R8 setclr", r, 32'hFF00_FF0F);
      check("R10 pad map", pad_out, {6'h0, 32'hFF00_FF0F, 32'h0});
   endtask

   task automatic t_bank2();
      logic [31:0] r;
      bus_write(12'h200, 32'hFFFF_FFFF);
      bus_read(12'h200, r); check("R11 bank2 dout", r, 32'h3F);
      check("R10 bank2 pads", pad_out[69:64], 6'h3F);
      bus_write(12'h300, 32'hD42F);
      bus_write(12'h20C, 32'hFFFF_FFFF);
      bus_write(12'h300, 32'h0);
      bus_read(12'h20C, r); check("R11 bank2 mode0", r, 32'h3F);
      check("R5 bank2 push", pad_oe[69:64], 6'h3F);
   endtask

   task automatic t_unmapped();
      logic [31:0] r;
      bus_write(12'h000, 32'h1234_5678);
      bus_write(12'h01C, 32'hFFFF_FFFF);
      bus_write(12'h400, 32'hFFFF_FFFF);
      bus_read(12'h000, r); check("R11 no alias", r, 32'h1234_5678);
      bus_read(12'h01C, r); check("R11 gap reads 0", r, 0);
      bus_read(12'h400, r); check("R11 no bank", r, 0);
      bus_read(12'h304, r); check("R11 near lock", r, 0);
      bus_read(12'h054, r); check("R11 alias reads 0", r, 0);
   endtask

   task automatic t_datain();
      logic [31:0] r;
      pad_in = '0;
      repeat (3) @(posedge clk);
      @(negedge clk); pad_in = {6'h2A, 32'h0, 32'hA5A5_0F0F}; addr = 12'h004; rd_en = 1'b1;
      @(posedge clk); @(negedge clk); check("R9 edge1 old", rd_data, 0);
      @(posedge clk); @(negedge clk); check("R9 edge2 old", rd_data, 0);
      @(posedge clk); @(negedge clk); check("R9 edge3 new", rd_data, 32'hA5A5_0F0F);
      rd_en = 1'b0;
      @(negedge clk); check("R12 hold", rd_data, 32'hA5A5_0F0F);
      bus_read(12'h204, r); check("R9 bank2 in", r, 32'h2A);
      bus_read(12'h200, r); check("R9 R12 dout differs", r, 32'h3F);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      t_reset();
      t_lock();
      t_protect();
      t_modes();
      t_data();
      t_bank2();
      t_unmapped();
      t_datain();
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule